// File: doc/BRIEF.md
# Sequenced Square-Plus-Double Datapath

This block evaluates x·x + 2·x for one unsigned input value using a shared datapath instead of a dedicated combinational polynomial circuit. The datapath holds two working registers and one arithmetic unit. The arithmetic unit can pass its first operand through, add its two operands, or multiply them. Two operand multiplexers choose what feeds the arithmetic unit. A small state machine produces every load enable, multiplexer select and operation code in a fixed four-step schedule.

A request is a one-cycle `start_i` pulse while the block is idle. On that pulse the block copies `x_i` into an internal holding register, so the caller may change `x_i` immediately afterwards. The steps run in this order. First, x is copied into both working registers. Second, the first register becomes x squared. Third, x is added to the first register. Fourth, x is added once more and the sum is shown on `result_o`, with `done_o` high for that single cycle. The machine then goes back to idle.

The result is twice as wide as the input. For an unsigned n-bit x, x·x + 2·x = (x+1)² − 1 ≤ 2^(2n) − 1, so the full result always fits in the output.

Top module: `poly_seq_unit`

## Requirements
- R1: After reset, and at any time while idle with no request, `done_o` is 0.
- R2: In the cycle `done_o` is 1, `result_o` equals x·x + 2·x for the x captured by the request. x is unsigned.
- R3: A request is sampled at a rising clock edge. `done_o` is then 1 in the clock period that starts at the third rising edge after that sampling edge, and 0 in the periods before it.
- R4: `done_o` is high for exactly one clock period per request.
- R5: `x_i` is sampled only at the edge that accepts the request. Later changes to `x_i` do not change the result.
- R6: `start_i` is ignored while a computation is in progress, including the period in which `done_o` is 1. After completion, a new request is accepted from idle.
- R7: The result keeps the full 2·XW-bit width without truncation. For the all-ones input the result is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; accepted only while idle |
| x_i | input | XW | Unsigned operand, sampled on an accepted request |
| result_o | output | 2*XW | Arithmetic unit output; holds the result while done_o is 1 |
| done_o | output | 1 | High for one cycle when result_o is valid |

## Verification
The assertions assume that `start_i` and `x_i` change only away from the active clock edge. They also assume that a request starts from idle, so the latency property holds only for pulses accepted in idle. The bench drives all inputs on falling edges. It sweeps every 8-bit x value as a clean request. It repeats selected values while holding `start_i` high and inverting `x_i` throughout the computation. This exercises the ignored-input cases without breaking the assumptions of the latency and result properties.

// File: rtl/poly_pkg.sv
package poly_pkg;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_ADD  = 2'd1,
        OP_MUL  = 2'd2
    } alu_op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEED = 3'd1,
        ST_SQR  = 3'd2,
        ST_ACC1 = 3'd3,
        ST_ACC2 = 3'd4
    } seq_state_e;

    // control word issued to the datapath each cycle
    typedef struct packed {
        logic    cap_x;   // copy external operand into holding register
        logic    ld_a;    // load working register A from ALU
        logic    ld_b;    // load working register B from ALU
        logic    sel_a;   // 0: held x, 1: register A (first operand)
        logic    sel_b;   // 0: register A, 1: register B (second operand)
        alu_op_e op;
    } ctrl_word_t;

endpackage

// File: rtl/poly_alu.sv
module poly_alu
    import poly_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   y_o
);

    logic [2*W-1:0] prod;

    always_comb begin
        prod = a_i * b_i;
        unique case (op_i)
            OP_PASS: y_o = a_i;
            OP_ADD:  y_o = a_i + b_i;
            OP_MUL:  y_o = prod[W-1:0];
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/poly_ctrl.sv
module poly_ctrl
    import poly_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output ctrl_word_t cw_o,
    output logic       done_o
);

    typedef struct packed {
        seq_state_e st;
    } ctrl_reg_t;

    ctrl_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: if (start_i) r_d.st = ST_SEED;
            ST_SEED: r_d.st = ST_SQR;
            ST_SQR:  r_d.st = ST_ACC1;
            ST_ACC1: r_d.st = ST_ACC2;
            ST_ACC2: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE};
        else        r_q <= r_d;
    end

    // control schedule, decoded from the current step
    always_comb begin
        cw_o   = '{cap_x: 1'b0, ld_a: 1'b0, ld_b: 1'b0,
                   sel_a: 1'b0, sel_b: 1'b0, op: OP_PASS};
        done_o = 1'b0;
        unique case (r_q.st)
            ST_IDLE: cw_o.cap_x = start_i;
            ST_SEED: begin
                cw_o.op   = OP_PASS;
                cw_o.ld_a = 1'b1;
                cw_o.ld_b = 1'b1;
            end
            ST_SQR: begin
                cw_o.sel_a = 1'b1;
                cw_o.sel_b = 1'b1;
                cw_o.op    = OP_MUL;
                cw_o.ld_a  = 1'b1;
            end
            ST_ACC1: begin
                cw_o.op   = OP_ADD;
                cw_o.ld_a = 1'b1;
            end
            ST_ACC2: begin
                cw_o.op = OP_ADD;
                done_o  = 1'b1;
            end
            default: ;
        endcase
    end

    // R3: fixed latency from an accepted request to completion
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && r_q.st == ST_IDLE) |-> ##4 done_o);

    // R4: completion lasts a single cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1: idle never loads the working registers
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> (!cw_o.ld_a && !cw_o.ld_b && !done_o));

    // R6: a request while busy does not restart the sequence
    a_r6_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && r_q.st != ST_IDLE) |=> (r_q.st != ST_SEED));

endmodule

// File: rtl/poly_datapath.sv
module poly_datapath
    import poly_pkg::*;
#(
    parameter int XW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_word_t        cw_i,
    input  logic [XW-1:0]     x_i,
    output logic [2*XW-1:0]   y_o,
    output logic [XW-1:0]     x_held_o
);

    localparam int RW = 2 * XW;

    typedef struct packed {
        logic [XW-1:0] x;
        logic [RW-1:0] ra;
        logic [RW-1:0] rb;
    } dp_reg_t;

    dp_reg_t r_d, r_q;
    logic [RW-1:0] opnd_a, opnd_b, alu_y;

    always_comb begin
        opnd_a = cw_i.sel_a ? r_q.ra : {{XW{1'b0}}, r_q.x};
        opnd_b = cw_i.sel_b ? r_q.rb : r_q.ra;
    end

    poly_alu #(.W(RW)) u_alu (
        .op_i (cw_i.op),
        .a_i  (opnd_a),
        .b_i  (opnd_b),
        .y_o  (alu_y)
    );

    always_comb begin
        r_d = r_q;
        if (cw_i.cap_x) r_d.x  = x_i;
        if (cw_i.ld_a)  r_d.ra = alu_y;
        if (cw_i.ld_b)  r_d.rb = alu_y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign y_o      = alu_y;
    assign x_held_o = r_q.x;

    // R5: the held operand changes only on capture
    a_r5_hold_x: assert property (@(posedge clk) disable iff (!rst_n)
        !cw_i.cap_x |=> $stable(r_q.x));

    // R7: after the square step register A carries the full-width square
    a_r7_square_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_i.op == OP_MUL && cw_i.ld_a) |=>
            (r_q.ra == RW'(r_q.x) * RW'(r_q.x)));

endmodule

// File: rtl/poly_seq_unit.sv
module poly_seq_unit
    import poly_pkg::*;
#(
    parameter int XW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [XW-1:0]     x_i,
    output logic [2*XW-1:0]   result_o,
    output logic              done_o
);

    localparam int RW = 2 * XW;

    ctrl_word_t    cw;
    logic [XW-1:0] x_held;

    poly_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .cw_o    (cw),
        .done_o  (done_o)
    );

    poly_datapath #(.XW(XW)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cw_i     (cw),
        .x_i      (x_i),
        .y_o      (result_o),
        .x_held_o (x_held)
    );

    // R2: completed value matches the polynomial of the held operand
    a_r2_result: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o == RW'(x_held) * RW'(x_held) + 2 * RW'(x_held)));

endmodule

// File: tb/poly_seq_unit_tb.sv
module poly_seq_unit_tb;

    localparam int XW = 8;
    localparam int RW = 2 * XW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [XW-1:0] x_i = '0;
    logic [RW-1:0] result_o;
    logic          done_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    poly_seq_unit #(.XW(XW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .x_i      (x_i),
        .result_o (result_o),
        .done_o   (done_o)
    );

    task automatic chk(input bit ok, input string req,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one request; when disturb is set, start stays high and x is inverted
    // for the whole computation (R5, R6)
    task automatic run_one(input int xv, input bit disturb);
        longint exp;
        exp = longint'(xv) * xv + 2 * xv;
        @(negedge clk);
        x_i = XW'(xv);
        start_i = 1'b1;
        @(negedge clk);                       // after the sampling edge
        start_i = disturb;
        if (disturb) x_i = ~XW'(xv);
        chk(done_o == 1'b0, "R3 early+0", done_o, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R3 early+1", done_o, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R3 early+2", done_o, 0);
        @(negedge clk);                       // third edge after sampling
        chk(done_o == 1'b1, "R3 done", done_o, 1);
        chk(result_o == RW'(exp), disturb ? "R5 R6 result" : "R2 result",
            result_o, exp);
        if (xv == (1 << XW) - 1)
            chk(result_o == {RW{1'b1}}, "R7 full width", result_o, (1 << RW) - 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R4 single", done_o, 0);
        start_i = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b0, disturb ? "R6 no restart" : "R1 idle", done_o, 0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done_o == 1'b0, "R1 reset", done_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done_o == 1'b0, "R1 idle after reset", done_o, 0);
        for (int v = 0; v < (1 << XW); v++) run_one(v, 1'b0);
        run_one(0, 1'b1);
        run_one(7, 1'b1);
        run_one(170, 1'b1);
        run_one((1 << XW) - 1, 1'b1);
        run_one(3, 1'b0);   // normal request accepted after busy-ignore (R6)
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule